// File: doc/BRIEF.md
# Single-Bank Reordering Command Scheduler

This block takes read and write requests aimed at one DRAM bank and turns them into a stream of row-activate, read, write and precharge commands. It keeps one row open after a column access (open-page policy) and tracks that row itself. Reads and writes wait in two separate queues. Each queue keeps its entries in arrival order by position, so slot 0 always holds the oldest entry, even after an entry is removed from the middle.

At each decision point the scheduler first chooses a queue. Writes are served only when no read is waiting, or when the write queue has reached a fill threshold. Within the chosen queue it takes the oldest entry that hits the open row. If no entry hits, it takes the oldest entry. It then issues the command that moves that entry forward: activate when no row is open, precharge when another row is open, and the column command on a hit. A command is held on the output until the consumer accepts it. After each accept the output stays idle for a fixed gap.

Top module: `bank_cmd_sched`

## Requirements
- R1: With no row open, the scheduler issues ACT with the chosen request's row on `cmd_addr`, then the column command for that request. Opcodes on `cmd_op` are 2'b00 precharge, 2'b01 activate, 2'b10 read and 2'b11 write. Column commands carry the column on `cmd_addr`.
- R2: When the chosen request targets a row other than the open one, the sequence is PRE (address 0), then ACT of the new row, then the column command.
- R3: After a column command the row stays open. Later hits to that row get column commands with no PRE or ACT between them.
- R4: A queued request that hits the open row is served before an older request to a different row. Among several hits, the oldest is served first.
- R5: When no queued request hits the open row, the oldest request of the chosen queue is served.
- R6: While any read is queued and the write queue holds fewer than `WR_HI` entries, no write command is started.
- R7: When the write queue holds `WR_HI` or more entries, writes are served even with reads pending. This continues until the count drops below `WR_HI`.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values.
- R9: A request leaves its queue only when its column command is accepted. `cpl_valid` is high exactly on that accept, and `cpl_wr` is high when the command is a write.
- R10: After every accepted command, `cmd_valid` stays low for at least `IDLE_GAP`+1 cycles.
- R11: After reset no command is valid and no row is open. `req_ready` is high when the queue for the offered type (`req_wr`) is not full, and low when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue for the offered type has room |
| req_wr | input | 1 | 1 = write request, 0 = read request |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_op | output | 2 | Command opcode |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR, zero for PRE |
| cpl_valid | output | 1 | A column command was accepted this cycle |
| cpl_wr | output | 1 | The completed request was a write |

## Verification
The subtle point is a single decision in which the write-drain threshold and read priority both apply. To provoke it, a read is parked behind a held precharge while the write queue fills to its threshold. Once the precharge is accepted, the next choice must go to the writes. After one write is removed, the choice must return to the pending read.

The bench judges this case, and every other case, by comparing the accepted command stream, entry by entry, with the order worked out from the requirements. It also checks that commands stay stable under backpressure and that the idle gap after each accept is respected.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'b00,
    OP_ACT = 2'b01,
    OP_RD  = 2'b10,
    OP_WR  = 2'b11
  } cmd_op_e;
endpackage

// File: rtl/bsched_queue.sv
module bsched_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 12,
  parameter int COL_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  logic [ROW_W-1:0]               push_row_i,
  input  logic [COL_W-1:0]               push_col_i,
  input  logic                           pop_i,
  input  logic [$clog2(DEPTH)-1:0]       pop_idx_i,
  output logic [DEPTH-1:0]               vld_o,
  output logic [DEPTH-1:0][ROW_W-1:0]    rows_o,
  output logic [DEPTH-1:0][COL_W-1:0]    cols_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ROW_W-1:0] row_q, row_d;
  logic [DEPTH-1:0][COL_W-1:0] col_q, col_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d;

  // Removal compacts the younger entries down; arrival lands after the last entry.
  always_comb begin
    logic [CNT_W-1:0] fill;
    row_d = row_q;
    col_d = col_q;
    fill  = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx_i) begin
          row_d[i] = row_q[i+1];
          col_d[i] = col_q[i+1];
        end
      end
      fill = cnt_q - 1'b1;
    end
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == fill) begin
          row_d[i] = push_row_i;
          col_d[i] = push_col_i;
        end
      end
      fill = fill + 1'b1;
    end
    cnt_d = fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_i || pop_i) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign vld_o[g] = (CNT_W'(g) < cnt_q);
    end
  endgenerate

  assign rows_o = row_q;
  assign cols_o = col_q;
  assign cnt_o  = cnt_q;

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |-> cnt_q < CNT_W'(DEPTH));
  a_r9_pop_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> CNT_W'(pop_idx_i) < cnt_q);
endmodule

// File: rtl/bsched_pick.sv
module bsched_pick #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 12
) (
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [DEPTH-1:0][ROW_W-1:0] rows_i,
  input  logic                        open_i,
  input  logic [ROW_W-1:0]            open_row_i,
  output logic                        any_o,
  output logic                        hit_o,
  output logic [$clog2(DEPTH)-1:0]    idx_o
);
  localparam int IDX_W = $clog2(DEPTH);

  // Scan from youngest to oldest so the lowest (oldest) hit wins.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_i[i] && open_i && (rows_i[i] == open_row_i)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o = vld_i[0];
endmodule

// File: rtl/bank_cmd_sched.sv
module bank_cmd_sched
  import bsched_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int RQ_DEPTH = 4,
  parameter int WQ_DEPTH = 4,
  parameter int WR_HI    = WQ_DEPTH,
  parameter int IDLE_GAP = 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_wr,
  input  logic [ROW_W-1:0]                       req_row,
  input  logic [COL_W-1:0]                       req_col,
  output logic                                   cmd_valid,
  input  logic                                   cmd_ready,
  output logic [1:0]                             cmd_op,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic                                   cpl_valid,
  output logic                                   cpl_wr
);
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RIDX_W  = $clog2(RQ_DEPTH);
  localparam int WIDX_W  = $clog2(WQ_DEPTH);
  localparam int RCNT_W  = $clog2(RQ_DEPTH + 1);
  localparam int WCNT_W  = $clog2(WQ_DEPTH + 1);
  localparam int SEL_W   = (RIDX_W > WIDX_W) ? RIDX_W : WIDX_W;
  localparam int GAP_W   = $clog2(IDLE_GAP + 2);

  // Queue state
  logic [RQ_DEPTH-1:0]             r_vld;
  logic [RQ_DEPTH-1:0][ROW_W-1:0]  r_rows;
  logic [RQ_DEPTH-1:0][COL_W-1:0]  r_cols;
  logic [RCNT_W-1:0]               r_cnt;
  logic [WQ_DEPTH-1:0]             w_vld;
  logic [WQ_DEPTH-1:0][ROW_W-1:0]  w_rows;
  logic [WQ_DEPTH-1:0][COL_W-1:0]  w_cols;
  logic [WCNT_W-1:0]               w_cnt;

  // Bank and output registers
  logic              open_q, open_d;
  logic [ROW_W-1:0]  open_row_q, open_row_d;
  logic              cv_q, cv_d;
  cmd_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  logic r_push, w_push, r_pop, w_pop, accept, load;
  logic r_any, r_hit, w_any, w_hit, use_wr, pk_hit;
  logic [RIDX_W-1:0] r_idx;
  logic [WIDX_W-1:0] w_idx;
  logic [ROW_W-1:0]  pk_row;
  logic [COL_W-1:0]  pk_col;

  assign req_ready = req_wr ? (w_cnt < WCNT_W'(WQ_DEPTH)) : (r_cnt < RCNT_W'(RQ_DEPTH));
  assign r_push    = req_valid && req_ready && !req_wr;
  assign w_push    = req_valid && req_ready &&  req_wr;
  assign accept    = cv_q && cmd_ready;
  assign r_pop     = accept && (op_q == OP_RD);
  assign w_pop     = accept && (op_q == OP_WR);

  bsched_queue #(.DEPTH(RQ_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_rq (
    .clk, .rst_n, .push_i(r_push), .push_row_i(req_row), .push_col_i(req_col),
    .pop_i(r_pop), .pop_idx_i(RIDX_W'(sel_q)),
    .vld_o(r_vld), .rows_o(r_rows), .cols_o(r_cols), .cnt_o(r_cnt));

  bsched_queue #(.DEPTH(WQ_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_wq (
    .clk, .rst_n, .push_i(w_push), .push_row_i(req_row), .push_col_i(req_col),
    .pop_i(w_pop), .pop_idx_i(WIDX_W'(sel_q)),
    .vld_o(w_vld), .rows_o(w_rows), .cols_o(w_cols), .cnt_o(w_cnt));

  bsched_pick #(.DEPTH(RQ_DEPTH), .ROW_W(ROW_W)) u_rpick (
    .vld_i(r_vld), .rows_i(r_rows), .open_i(open_q), .open_row_i(open_row_q),
    .any_o(r_any), .hit_o(r_hit), .idx_o(r_idx));

  bsched_pick #(.DEPTH(WQ_DEPTH), .ROW_W(ROW_W)) u_wpick (
    .vld_i(w_vld), .rows_i(w_rows), .open_i(open_q), .open_row_i(open_row_q),
    .any_o(w_any), .hit_o(w_hit), .idx_o(w_idx));

  // Queue choice: reads first unless the write queue is at its threshold.
  assign use_wr = w_any && (!r_any || (w_cnt >= WCNT_W'(WR_HI)));
  assign pk_hit = use_wr ? w_hit : r_hit;
  assign pk_row = use_wr ? w_rows[w_idx] : r_rows[r_idx];
  assign pk_col = use_wr ? w_cols[w_idx] : r_cols[r_idx];
  assign load   = !cv_q && (gap_q == '0) && (r_any || w_any);

  always_comb begin
    cv_d       = cv_q;
    op_d       = op_q;
    addr_d     = addr_q;
    sel_d      = sel_q;
    gap_d      = gap_q;
    open_d     = open_q;
    open_row_d = open_row_q;
    if (accept) begin
      cv_d  = 1'b0;
      gap_d = GAP_W'(IDLE_GAP);
      if (op_q == OP_ACT) begin
        open_d     = 1'b1;
        open_row_d = addr_q[ROW_W-1:0];
      end else if (op_q == OP_PRE) begin
        open_d = 1'b0;
      end
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end else if (load) begin
      cv_d  = 1'b1;
      sel_d = use_wr ? SEL_W'(w_idx) : SEL_W'(r_idx);
      if (!open_q) begin
        op_d   = OP_ACT;
        addr_d = ADDR_W'(pk_row);
      end else if (!pk_hit) begin
        op_d   = OP_PRE;
        addr_d = '0;
      end else begin
        op_d   = use_wr ? OP_WR : OP_RD;
        addr_d = ADDR_W'(pk_col);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q   <= 1'b0;
      open_q <= 1'b0;
      gap_q  <= '0;
      op_q   <= OP_PRE;
      sel_q  <= '0;
    end else begin
      cv_q   <= cv_d;
      open_q <= open_d;
      gap_q  <= gap_d;
      op_q   <= op_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load || accept) begin
      addr_q     <= addr_d;
      open_row_q <= open_row_d;
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_op    = op_q;
  assign cmd_addr  = addr_q;
  assign cpl_valid = accept && op_q[1];
  assign cpl_wr    = op_q == OP_WR;

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q && !cmd_ready |=> cv_q && $stable(op_q) && $stable(addr_q));
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cv_q);
  a_r1_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q && (op_q == OP_ACT) |-> !open_q);
  a_r2_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q && (op_q == OP_PRE) |-> open_q);
  a_r3_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q && op_q[1] |-> open_q);
  a_r6_wr_defer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_q) && (op_q == OP_WR) |->
      ($past(r_cnt) == '0) || ($past(w_cnt) >= WCNT_W'(WR_HI)));
endmodule

// File: tb/bank_cmd_sched_tb.sv
module bank_cmd_sched_tb;
  localparam int ROW_W = 12, COL_W = 10, ADDR_W = 12, GAP = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_wr;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic cmd_valid, cmd_ready, cpl_valid, cpl_wr;
  logic [1:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  int n_cmp = 0, n_bad = 0;
  int exp_op[$];
  int exp_addr[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  bank_cmd_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .RQ_DEPTH(4), .WQ_DEPTH(4),
                   .WR_HI(4), .IDLE_GAP(GAP)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_row, .req_col,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr, .cpl_valid, .cpl_wr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input int op, input int addr, input string tag);
    exp_op.push_back(op);
    exp_addr.push_back(addr);
    exp_tag.push_back(tag);
  endtask

  task automatic push_req(input bit wr, input int row, input int col);
    @(posedge clk); #1;
    req_valid = 1'b1; req_wr = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready with room", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_ready(input bit v);
    @(posedge clk); #1;
    cmd_ready = v;
  endtask

  task automatic drain();
    while (exp_op.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Monitor: scoreboard compare, hold and gap checks
  bit prev_v = 1'b0, prev_r = 1'b0, seen_acc = 1'b0;
  int prev_op = 0, prev_addr = 0, low_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_v = 1'b0; seen_acc = 1'b0; low_cnt = 0;
    end else begin
      if (cmd_valid) begin
        if (!prev_v && seen_acc)
          chk(low_cnt >= GAP + 1, "R10 idle gap", low_cnt, GAP + 1);
        if (prev_v && !prev_r) begin
          chk(int'(cmd_op) == prev_op, "R8 op held", int'(cmd_op), prev_op);
          chk(int'(cmd_addr) == prev_addr, "R8 addr held", int'(cmd_addr), prev_addr);
        end
      end else if (prev_v && !prev_r) begin
        chk(1'b0, "R8 valid dropped", 0, 1);
      end
      if (cmd_valid && cmd_ready) begin
        if (exp_op.size() == 0) begin
          chk(1'b0, "R9 unexpected command", int'(cmd_op), -1);
        end else begin
          int eo, ea;
          string et;
          eo = exp_op.pop_front(); ea = exp_addr.pop_front(); et = exp_tag.pop_front();
          chk(int'(cmd_op) == eo, {et, " op"}, int'(cmd_op), eo);
          chk(int'(cmd_addr) == ea, {et, " addr"}, int'(cmd_addr), ea);
          chk(cpl_valid == cmd_op[1], "R9 completion pulse", int'(cpl_valid), int'(cmd_op[1]));
          if (cmd_op[1]) chk(cpl_wr == cmd_op[0], "R9 completion type", int'(cpl_wr), int'(cmd_op[0]));
        end
        low_cnt = 0; seen_acc = 1'b1;
      end else begin
        chk(cpl_valid == 1'b0, "R9 no completion without accept", int'(cpl_valid), 0);
        if (!cmd_valid) low_cnt++;
      end
      prev_v = cmd_valid; prev_r = cmd_ready;
      prev_op = int'(cmd_op); prev_addr = int'(cmd_addr);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam int PRE = 0, ACT = 1, RD = 2, WR = 3;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_row = '0; req_col = '0;
    cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R11 reset no command", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // S1: hit served ahead of an older conflicting request
    expect_cmd(ACT, 0, "R1 act on closed bank");
    expect_cmd(RD,  0, "R1 column after act");
    expect_cmd(RD,  1, "R4 younger hit before older conflict");
    expect_cmd(PRE, 0, "R2 precharge on conflict");
    expect_cmd(ACT, 1, "R2 act new row");
    expect_cmd(RD,  0, "R2 column after reopen");
    push_req(1'b0, 0, 0);
    push_req(1'b0, 1, 0);
    push_req(1'b0, 0, 1);
    @(negedge clk);
    chk(cmd_valid == 1'b1 && cmd_op == 2'd1, "R8 act held under backpressure", int'(cmd_op), ACT);
    set_ready(1'b1);
    drain();

    // S2: writes deferred behind a read (row 1 open)
    set_ready(1'b0);
    expect_cmd(PRE, 0, "R6 read goes first");
    expect_cmd(ACT, 2, "R6 read row");
    expect_cmd(RD,  3, "R6 read column");
    expect_cmd(PRE, 0, "R6 writes after reads");
    expect_cmd(ACT, 1, "R6 write row");
    expect_cmd(WR,  5, "R6 first write");
    expect_cmd(WR,  6, "R3 second write no reopen");
    push_req(1'b0, 2, 3);
    push_req(1'b1, 1, 5);
    push_req(1'b1, 1, 6);
    set_ready(1'b1);
    drain();

    // S3: full write queue drains ahead of a pending read (row 1 open)
    set_ready(1'b0);
    expect_cmd(PRE, 0, "R7 precharge for read");
    expect_cmd(ACT, 1, "R7 full queue takes over");
    expect_cmd(WR,  0, "R7 drain one write");
    expect_cmd(PRE, 0, "R7 below threshold back to read");
    expect_cmd(ACT, 3, "R7 read row");
    expect_cmd(RD,  7, "R7 read column");
    expect_cmd(PRE, 0, "R6 writes resume");
    expect_cmd(ACT, 1, "R6 write row");
    expect_cmd(WR,  1, "R3 write hit");
    expect_cmd(WR,  2, "R3 write hit");
    expect_cmd(WR,  3, "R3 write hit");
    push_req(1'b0, 3, 7);
    for (int c = 0; c < 4; c++) push_req(1'b1, 1, c);
    @(posedge clk); #1 req_wr = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 write queue full", int'(req_ready), 0);
    @(posedge clk); #1 req_wr = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 read queue has room", int'(req_ready), 1);
    set_ready(1'b1);
    drain();

    // S4: oldest when no hit, oldest among hits (row 1 open)
    set_ready(1'b0);
    expect_cmd(PRE, 0, "R5 conflict on oldest");
    expect_cmd(ACT, 5, "R5 oldest with closed bank");
    expect_cmd(RD,  0, "R5 oldest served");
    expect_cmd(PRE, 0, "R5 no hit precharge");
    expect_cmd(ACT, 1, "R5 next oldest row");
    expect_cmd(RD,  9, "R4 oldest hit first");
    expect_cmd(RD,  8, "R4 younger hit next");
    expect_cmd(PRE, 0, "R2 conflict");
    expect_cmd(ACT, 6, "R2 act");
    expect_cmd(RD,  1, "R5 last request");
    push_req(1'b0, 5, 0);
    push_req(1'b0, 1, 9);
    push_req(1'b0, 6, 1);
    push_req(1'b0, 1, 8);
    repeat (3) @(negedge clk);
    set_ready(1'b1);
    drain();
    chk(cmd_valid == 1'b0, "R9 idle after all served", int'(cmd_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule